// File: doc/BRIEF.md
# Trigger-Aware Decimating FIFO Enable Generator

This block drives the write-enable and read-enable strobes of a sample FIFO in a triggered acquisition path. A controller grants write and read permission, switches decimation on or off, and signals when a trigger has been seen. Before the trigger, the block thins the strobes by a 2-bit ratio. It does this only by suppressing enable pulses. The clock runs freely and is never gated or divided. After the trigger, every permitted cycle yields a strobe. The result is that pre-trigger history is stored decimated and post-trigger data is stored at full rate.

A free-running 3-bit phase counter sets which cycles may produce a strobe. Every cycle, a mode selector places the block in one of three states:

- FULL_RATE: decimation is switched off.
- PRE_TRIG: decimation is on and no trigger has been seen.
- POST_TRIG: decimation is on and the trigger has been seen.

The state follows the inputs of the current cycle, so every transition between states is immediate:

- FULL_RATE to PRE_TRIG when decimation is enabled.
- PRE_TRIG to POST_TRIG when the trigger flag asserts.
- Any state to FULL_RATE when decimation is disabled.
- POST_TRIG to PRE_TRIG when the trigger flag drops.

The strobe outputs are registered, so both strobes lag their qualifying cycle by one clock. All control signals are active low.

Top module: `dcm_enable_gen`

## Requirements
- R1: While `rst_n` is low, both `fifo_we_n` and `fifo_re_n` are high and the phase counter is zero.
- R2: In PRE_TRIG with `ratio` = 00, every cycle with write permission produces a write strobe.
- R3: In PRE_TRIG with `ratio` = 01, 10 or 11 (1:2, 1:4, 1:8), a strobe is allowed only in cycles where the low 1, 2 or 3 bits of the phase counter are zero. The counter is zero in the first cycle that `dec_en_n` is low, so the first such cycle is kept.
- R4: With `trig_n` low and decimation enabled (POST_TRIG), a strobe follows every permitted cycle, whatever the ratio.
- R5: With `dec_en_n` high (FULL_RATE), a strobe follows every permitted cycle, and the phase counter is held at zero.
- R6: `fifo_we_n` goes low only one cycle after a cycle in which `wr_allow_n` was low. `fifo_re_n` goes low only one cycle after a cycle in which `rd_allow_n` was low.
- R7: Both strobes have the same one-clock latency and use the same phase. When both permissions are low in a cycle, the next `fifo_we_n` equals the next `fifo_re_n`.
- R8: In PRE_TRIG with a nonzero ratio, each kept write strobe lasts exactly one cycle. Two consecutive cycles never both show `fifo_we_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_en_n | input | 1 | Decimation enable, active low |
| trig_n | input | 1 | Trigger-received flag, active low |
| ratio | input | 2 | Decimation ratio: 00 = 1:1, 01 = 1:2, 10 = 1:4, 11 = 1:8 |
| wr_allow_n | input | 1 | Write permission from the controller, active low |
| rd_allow_n | input | 1 | Read permission from the controller, active low |
| fifo_we_n | output | 1 | FIFO write-enable strobe, active low |
| fifo_re_n | output | 1 | FIFO read-enable strobe, active low |

## Verification
The trigger bypass and the decimation phase can fall in the same cycle. This happens when `trig_n` asserts or releases while the phase counter is not aligned. The bench provokes it by toggling the trigger flag partway through a 1:8 window. It judges the result against a behavioural reference that tracks the phase as an integer: a strobe is expected on the cycle right after the trigger, and the phase must still be correct once the trigger releases. A second pairing, a decimation ratio change during a running count, is exercised the same way.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [1:0] {
        MODE_FULL_RATE = 2'd0,
        MODE_PRE_TRIG  = 2'd1,
        MODE_POST_TRIG = 2'd2
    } dcm_mode_e;

endpackage

// File: rtl/dcm_phase_ctr.sv
module dcm_phase_ctr #(
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_zero,
    output logic [PHASE_W-1:0] phase
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (hold_zero) begin
            phase <= '0;
        end else begin
            phase <= phase + {{(PHASE_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/dcm_mode_sel.sv
module dcm_mode_sel
    import dcm_pkg::*;
#(
    parameter int RATIO_W = 2,
    parameter int PHASE_W = 3
) (
    input  logic               dec_en_n,
    input  logic               trig_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [PHASE_W-1:0] phase,
    output logic               keep
);

    dcm_mode_e          mode;
    logic [PHASE_W:0]   span;
    logic [PHASE_W-1:0] mask;

    always_comb begin
        if (dec_en_n) begin
            mode = MODE_FULL_RATE;
        end else if (!trig_n) begin
            mode = MODE_POST_TRIG;
        end else begin
            mode = MODE_PRE_TRIG;
        end
    end

    always_comb begin
        span = ({{PHASE_W{1'b0}}, 1'b1} << ratio) - {{PHASE_W{1'b0}}, 1'b1};
        mask = span[PHASE_W-1:0];
    end

    always_comb begin
        unique case (mode)
            MODE_FULL_RATE: keep = 1'b1;
            MODE_POST_TRIG: keep = 1'b1;
            MODE_PRE_TRIG:  keep = ((phase & mask) == '0);
            default:        keep = 1'b1;
        endcase
    end

endmodule

// File: rtl/dcm_strobe_reg.sv
module dcm_strobe_reg #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           keep,
    input  logic [NCH-1:0] allow_n,
    output logic [NCH-1:0] strobe_n
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                strobe_n[g] <= 1'b1;
            end else begin
                strobe_n[g] <= ~(~allow_n[g] & keep);
            end
        end
    end

endmodule

// File: rtl/dcm_enable_gen.sv
module dcm_enable_gen #(
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_en_n,
    input  logic               trig_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               wr_allow_n,
    input  logic               rd_allow_n,
    output logic               fifo_we_n,
    output logic               fifo_re_n
);

    localparam int PHASE_W = (1 << RATIO_W) - 1;
    localparam int NCH     = 2;

    logic [PHASE_W-1:0] phase;
    logic               keep;
    logic [NCH-1:0]     allow_n;
    logic [NCH-1:0]     strobe_n;

    dcm_phase_ctr #(.PHASE_W(PHASE_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (dec_en_n),
        .phase     (phase)
    );

    dcm_mode_sel #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_mode (
        .dec_en_n (dec_en_n),
        .trig_n   (trig_n),
        .ratio    (ratio),
        .phase    (phase),
        .keep     (keep)
    );

    assign allow_n = {rd_allow_n, wr_allow_n};

    dcm_strobe_reg #(.NCH(NCH)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .keep     (keep),
        .allow_n  (allow_n),
        .strobe_n (strobe_n)
    );

    assign fifo_we_n = strobe_n[0];
    assign fifo_re_n = strobe_n[1];

endmodule

// File: rtl/dcm_enable_gen_chk.sv
module dcm_enable_gen_chk #(
    parameter int RATIO_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dec_en_n,
    input logic               trig_n,
    input logic [RATIO_W-1:0] ratio,
    input logic               wr_allow_n,
    input logic               rd_allow_n,
    input logic               fifo_we_n,
    input logic               fifo_re_n
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_idle_in_reset_R1: assert (fifo_we_n && fifo_re_n);
        end
    end

    assert_we_needs_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_we_n |-> $past(!wr_allow_n));

    assert_re_needs_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_re_n |-> $past(!rd_allow_n));

    assert_post_trig_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow_n && !trig_n) |=> !fifo_we_n);

    assert_bypass_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow_n && dec_en_n) |=> !fifo_we_n);

    assert_shared_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow_n && !rd_allow_n) |=> (fifo_we_n == fifo_re_n));

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_we_n && !dec_en_n && trig_n && (ratio != '0)
         && $past(!dec_en_n) && $past(trig_n) && $past(rst_n)) |=> fifo_we_n);

endmodule

bind dcm_enable_gen dcm_enable_gen_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_en_n   (dec_en_n),
    .trig_n     (trig_n),
    .ratio      (ratio),
    .wr_allow_n (wr_allow_n),
    .rd_allow_n (rd_allow_n),
    .fifo_we_n  (fifo_we_n),
    .fifo_re_n  (fifo_re_n)
);

// File: tb/dcm_enable_gen_tb.sv
`timescale 1ns/1ps
module dcm_enable_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       dec_en_n = 1'b1;
    logic       trig_n = 1'b1;
    logic [1:0] ratio = 2'b00;
    logic       wr_allow_n = 1'b1;
    logic       rd_allow_n = 1'b1;
    logic       fifo_we_n;
    logic       fifo_re_n;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    logic exp_we = 1'b1;
    logic exp_re = 1'b1;
    logic both_perm = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    dcm_enable_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_en_n   (dec_en_n),
        .trig_n     (trig_n),
        .ratio      (ratio),
        .wr_allow_n (wr_allow_n),
        .rd_allow_n (rd_allow_n),
        .fifo_we_n  (fifo_we_n),
        .fifo_re_n  (fifo_re_n)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference: integer phase, keep rule from the requirements
    task automatic model_edge();
        bit keep;
        both_perm = !wr_allow_n && !rd_allow_n;
        if (!rst_n) begin
            exp_we = 1'b1;
            exp_re = 1'b1;
            ph = 0;
        end else begin
            keep = dec_en_n || !trig_n || (ratio == 2'b00) || ((ph % (1 << ratio)) == 0);
            exp_we = !(!wr_allow_n && keep);
            exp_re = !(!rd_allow_n && keep);
            ph = dec_en_n ? 0 : (ph + 1) % 8;
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check(tag, fifo_we_n, exp_we, "fifo_we_n");
            check(tag, fifo_re_n, exp_re, "fifo_re_n");
            if (both_perm) check("R7", fifo_we_n, fifo_re_n, "we/re equal");
        end
    endtask

    initial begin
        #2 rst_n = 1'b0;
        for (int i = 0; i < 3; i++) @(posedge clk);
        @(negedge clk);
        // R1: reset holds both strobes inactive
        check("R1", fifo_we_n, 1'b1, "fifo_we_n in reset");
        check("R1", fifo_re_n, 1'b1, "fifo_re_n in reset");
        wr_allow_n = 1'b0;
        rd_allow_n = 1'b0;
        run(2, "R1");
        rst_n = 1'b1;

        // R5: decimation off -> full rate even with 1:8 set
        ratio = 2'b11;
        run(10, "R5");

        // R2: ratio 00 pre-trigger
        dec_en_n = 1'b0;
        ratio = 2'b00;
        run(12, "R2");

        // R3: 1:2, 1:4, 1:8, each from a fresh phase
        for (int r = 1; r < 4; r++) begin
            dec_en_n = 1'b1;
            run(1, "R3");
            dec_en_n = 1'b0;
            ratio = 2'(r);
            run(20, "R3");
        end

        // R3: ratio change while the count is running
        ratio = 2'b10;
        run(5, "R3");
        ratio = 2'b01;
        run(6, "R3");

        // R4: trigger arrives mid-window at 1:8, then releases
        ratio = 2'b11;
        run(3, "R4");
        trig_n = 1'b0;
        run(10, "R4");
        trig_n = 1'b1;
        run(12, "R4");

        // R6: permissions independent
        wr_allow_n = 1'b0;
        rd_allow_n = 1'b1;
        ratio = 2'b00;
        run(6, "R6");
        wr_allow_n = 1'b1;
        rd_allow_n = 1'b0;
        run(6, "R6");
        for (int i = 0; i < 12; i++) begin
            wr_allow_n = i[0];
            rd_allow_n = i[1];
            run(1, "R6");
        end

        // R7: both permissions at 1:4, shared phase
        wr_allow_n = 1'b0;
        rd_allow_n = 1'b0;
        ratio = 2'b10;
        run(16, "R7");

        // R8: single-cycle strobes at 1:2 and 1:8
        ratio = 2'b01;
        run(10, "R8");
        ratio = 2'b11;
        run(17, "R8");

        // R1: reset mid-run
        rst_n = 1'b0;
        run(3, "R1");
        rst_n = 1'b1;
        run(9, "R3");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule